// File: doc/BRIEF.md
# DRAM Access Cycle State Sequencer

This block times one DRAM bus cycle at a time. A requester raises either an access request, with a read/write direction, or a refresh request. The sequencer then walks the cycle through its precharge states, a row state and two column states. It can stretch the column phase with wait states. It drives the row and column strobes, a row/column address select, a write enable and a one-cycle completion pulse. The current state is also visible on a port, so a neighbouring address mux or data path can follow it.

Each cycle starts with one precharge state, or with two when the long-precharge option is chosen, and refresh obeys the same choice. Between the first and second column states the sequencer first inserts 0 to 3 programmed wait states. When external waiting is enabled, it then holds in wait states for as long as an active-low WAIT input is low. WAIT is captured on the falling clock edge. The configuration is latched when a request is accepted, so it can change freely while a cycle is in progress.

Top module: `dram_cycle_seq`

## Requirements
- R1: While rst_n is low, state_o is 0 (idle) and ras_o, cas_o, col_sel_o, we_o and done_o are all 0.
- R2: A request is accepted on a rising edge where the state is idle (0) or the final state of a cycle (6 or 8). If rfsh_req and acc_req are both high at that edge, the refresh is taken. An accepted request moves the state to 1. With no request the state goes to 0.
- R3: Precharge lasts one state (1) when cfg_tp2 is 0 and two states (1 then 2) when cfg_tp2 is 1. This rule holds for both access and refresh.
- R4: After precharge, an access passes through row (3), first column (4), zero or more waits (5) and second column (6). done_o is high for exactly the one cycle spent in state 6.
- R5: With cfg_pw_en at 1, exactly cfg_pw_cnt wait states (5) follow state 4 before any external wait is honoured. With cfg_pw_en at 0, no programmed waits are inserted.
- R6: With cfg_xw_en at 1, after the programmed waits, wait_n is captured on the falling edge of each state 4 or 5 cycle. A captured low adds one more state 5. This applies whatever cfg_pw_en is. With cfg_xw_en at 0, wait_n has no effect.
- R7: ras_o is high in states 3, 4, 5, 6 and 8. cas_o is high in states 4, 5, 6, 7 and 8. Both are low in idle and precharge.
- R8: col_sel_o (1 = column address) is high in states 4, 5 and 6 and low in all others. we_o is high in those states only for a write access (acc_wr was 1 when the request was accepted).
- R9: A refresh runs precharge, then state 7 (cas_o only), then state 8 (cas_o and ras_o, done_o high). It never enters state 5, whatever wait_n does.
- R10: The configuration inputs are latched when a request is accepted. Changing them during a cycle does not change that cycle's precharge length or wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state advances on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access request (level, sampled at acceptance points) |
| acc_wr | input | 1 | Access direction, 1 = write |
| rfsh_req | input | 1 | Refresh request, has priority over acc_req |
| cfg_tp2 | input | 1 | 1 selects two precharge states |
| cfg_pw_en | input | 1 | Enables programmed wait insertion |
| cfg_pw_cnt | input | 2 | Number of programmed wait states (0 to 3) |
| cfg_xw_en | input | 1 | Enables external wait via wait_n |
| wait_n | input | 1 | External wait, active low, captured on falling edges |
| state_o | output | 4 | Current state: 0 idle, 1 pre1, 2 pre2, 3 row, 4 col1, 5 wait, 6 col2, 7 refresh CAS, 8 refresh RAS+CAS |
| ras_o | output | 1 | Row strobe, active high |
| cas_o | output | 1 | Column strobe, active high |
| col_sel_o | output | 1 | Address select, 1 = column address |
| we_o | output | 1 | Write enable, active high |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the point where programmed waits hand over to external waiting. It holds WAIT low for fewer, equal and more cycles than the programmed count. A design that sampled WAIT during programmed waits, or that used the rising-edge value, would then show one wait too many or too few. It also pulls WAIT low during refresh and with external waiting disabled, where a wrong design would insert wait states. Simultaneous refresh and access requests check that refresh wins. Configuration is flipped right after acceptance, which a design reading the live inputs would follow. Random back-to-back traffic checks that a request held high at the done cycle starts the next precharge with no idle gap.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_PRE1    = 4'd1,
        ST_PRE2    = 4'd2,
        ST_ROW     = 4'd3,
        ST_COL1    = 4'd4,
        ST_WAIT    = 4'd5,
        ST_COL2    = 4'd6,
        ST_RF_CAS  = 4'd7,
        ST_RF_BOTH = 4'd8
    } seq_state_e;

endpackage

// File: rtl/dram_wait_capture.sv
`timescale 1ns/1ps
module dram_wait_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n,
    output logic wait_lo
);
    logic wait_lo_d, wait_lo_q;

    always_comb begin
        wait_lo_d = ~wait_n;
    end

    // falling-edge capture so the rising-edge FSM sees a settled value
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) wait_lo_q <= 1'b0;
        else        wait_lo_q <= wait_lo_d;
    end

    assign wait_lo = wait_lo_q;
endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             acc_wr,
    input  logic             rfsh_req,
    input  logic             cfg_tp2,
    input  logic             cfg_pw_en,
    input  logic [CNT_W-1:0] cfg_pw_cnt,
    input  logic             cfg_xw_en,
    input  logic             wait_lo,
    output seq_state_e       state,
    output logic             wr_act
);
    typedef struct packed {
        seq_state_e       st;
        logic             rfsh;
        logic             wr;
        logic             tp2;
        logic             pw_en;
        logic [CNT_W-1:0] pw_cnt;
        logic             xw_en;
        logic [CNT_W-1:0] wleft;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    always_comb begin
        ctl_d  = ctl_q;
        accept = 1'b0;
        case (ctl_q.st)
            ST_IDLE: accept = 1'b1;
            ST_PRE1: begin
                if (ctl_q.tp2)       ctl_d.st = ST_PRE2;
                else if (ctl_q.rfsh) ctl_d.st = ST_RF_CAS;
                else                 ctl_d.st = ST_ROW;
            end
            ST_PRE2: ctl_d.st = ctl_q.rfsh ? ST_RF_CAS : ST_ROW;
            ST_ROW: begin
                ctl_d.st    = ST_COL1;
                ctl_d.wleft = ctl_q.pw_en ? ctl_q.pw_cnt : '0;
            end
            ST_COL1, ST_WAIT: begin
                if (ctl_q.wleft != '0) begin
                    ctl_d.st    = ST_WAIT;
                    ctl_d.wleft = ctl_q.wleft - 1'b1;
                end else if (ctl_q.xw_en && wait_lo) begin
                    ctl_d.st = ST_WAIT;
                end else begin
                    ctl_d.st = ST_COL2;
                end
            end
            ST_RF_CAS: ctl_d.st = ST_RF_BOTH;
            ST_COL2, ST_RF_BOTH: accept = 1'b1;
            default: ctl_d.st = ST_IDLE;
        endcase

        if (accept) begin
            ctl_d.st = ST_IDLE;
            if (rfsh_req || acc_req) begin
                ctl_d.st     = ST_PRE1;
                ctl_d.rfsh   = rfsh_req;
                ctl_d.wr     = ~rfsh_req & acc_wr;
                ctl_d.tp2    = cfg_tp2;
                ctl_d.pw_en  = cfg_pw_en;
                ctl_d.pw_cnt = cfg_pw_cnt;
                ctl_d.xw_en  = cfg_xw_en;
                ctl_d.wleft  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign state  = ctl_q.st;
    assign wr_act = ctl_q.wr;

    // R3
    pre2_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PRE2) |-> ($past(ctl_q.st) == ST_PRE1 && ctl_q.tp2));

    // R4
    col2_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_COL2) |-> ($past(ctl_q.st) == ST_COL1 || $past(ctl_q.st) == ST_WAIT));

    // R6
    ext_wait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && $past(ctl_q.wleft) == '0) |-> ($past(wait_lo) && $past(ctl_q.xw_en)));

    // R9
    rf_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RF_CAS) |=> (ctl_q.st == ST_RF_BOTH));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE && ctl_q.st != ST_PRE1) |->
        ($stable(ctl_q.tp2) && $stable(ctl_q.pw_cnt) && $stable(ctl_q.xw_en) && $stable(ctl_q.pw_en)));
endmodule

// File: rtl/dram_strobe_dec.sv
`timescale 1ns/1ps
module dram_strobe_dec
    import dram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state,
    input  logic       wr_act,
    output logic       ras,
    output logic       cas,
    output logic       col_sel,
    output logic       we,
    output logic       done
);
    always_comb begin
        ras     = 1'b0;
        cas     = 1'b0;
        col_sel = 1'b0;
        done    = 1'b0;
        case (state)
            ST_ROW:               ras = 1'b1;
            ST_COL1, ST_WAIT:     begin ras = 1'b1; cas = 1'b1; col_sel = 1'b1; end
            ST_COL2:              begin ras = 1'b1; cas = 1'b1; col_sel = 1'b1; done = 1'b1; end
            ST_RF_CAS:            cas = 1'b1;
            ST_RF_BOTH:           begin ras = 1'b1; cas = 1'b1; done = 1'b1; end
            default:              ;
        endcase
        we = col_sel & wr_act;
    end

    // R7
    row_then_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras && !cas) |=> cas);

    // R8
    we_in_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> col_sel);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/dram_cycle_seq.sv
`timescale 1ns/1ps
module dram_cycle_seq
    import dram_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             acc_wr,
    input  logic             rfsh_req,
    input  logic             cfg_tp2,
    input  logic             cfg_pw_en,
    input  logic [CNT_W-1:0] cfg_pw_cnt,
    input  logic             cfg_xw_en,
    input  logic             wait_n,
    output logic [3:0]       state_o,
    output logic             ras_o,
    output logic             cas_o,
    output logic             col_sel_o,
    output logic             we_o,
    output logic             done_o
);
    logic       wait_lo;
    seq_state_e state;
    logic       wr_act;

    dram_wait_capture u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_n  (wait_n),
        .wait_lo (wait_lo)
    );

    dram_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .acc_wr     (acc_wr),
        .rfsh_req   (rfsh_req),
        .cfg_tp2    (cfg_tp2),
        .cfg_pw_en  (cfg_pw_en),
        .cfg_pw_cnt (cfg_pw_cnt),
        .cfg_xw_en  (cfg_xw_en),
        .wait_lo    (wait_lo),
        .state      (state),
        .wr_act     (wr_act)
    );

    dram_strobe_dec u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .wr_act  (wr_act),
        .ras     (ras_o),
        .cas     (cas_o),
        .col_sel (col_sel_o),
        .we      (we_o),
        .done    (done_o)
    );

    assign state_o = state;

    // R2
    done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_o == 4'd0 || state_o == 4'd1));
endmodule

// File: tb/dram_cycle_seq_tb.sv
`timescale 1ns/1ps
module dram_cycle_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0, acc_wr = 1'b0, rfsh_req = 1'b0;
    logic       cfg_tp2 = 1'b0, cfg_pw_en = 1'b0, cfg_xw_en = 1'b0;
    logic [1:0] cfg_pw_cnt = 2'd0;
    logic       wait_n = 1'b1;
    logic [3:0] state_o;
    logic       ras_o, cas_o, col_sel_o, we_o, done_o;

    int compared = 0, mismatched = 0, cyc = 0;
    bit finished = 0, cmp_on = 0;

    always #4 clk = ~clk;

    dram_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
        .rfsh_req(rfsh_req), .cfg_tp2(cfg_tp2), .cfg_pw_en(cfg_pw_en),
        .cfg_pw_cnt(cfg_pw_cnt), .cfg_xw_en(cfg_xw_en), .wait_n(wait_n),
        .state_o(state_o), .ras_o(ras_o), .cas_o(cas_o), .col_sel_o(col_sel_o),
        .we_o(we_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: phase number plus remaining programmed waits
    int m_st = 0, m_left = 0, m_cnt = 0;
    bit m_rf = 0, m_wr = 0, m_tp2 = 0, m_pw = 0, m_xw = 0;

    always @(posedge clk) begin : model
        int nxt;
        bit take;
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_rf = 0; m_wr = 0;
        end else begin
            take = 0;
            nxt  = m_st;
            if (m_st == 0 || m_st == 6 || m_st == 8) take = 1;
            else if (m_st == 1 || m_st == 2) begin
                if (m_st == 1 && m_tp2) nxt = 2;
                else nxt = m_rf ? 7 : 3;
            end else if (m_st == 3) begin
                nxt = 4;
                m_left = m_pw ? m_cnt : 0;
            end else if (m_st == 4 || m_st == 5) begin
                if (m_left > 0) begin m_left = m_left - 1; nxt = 5; end
                else if (m_xw && !wait_n) nxt = 5;
                else nxt = 6;
            end else if (m_st == 7) nxt = 8;
            if (take) begin
                nxt = 0;
                if (rfsh_req || acc_req) begin
                    nxt = 1; m_rf = rfsh_req; m_wr = !rfsh_req && acc_wr;
                    m_tp2 = cfg_tp2; m_pw = cfg_pw_en; m_cnt = int'(cfg_pw_cnt); m_xw = cfg_xw_en;
                end
            end
            m_st = nxt;
        end
    end

    function automatic string st_tag(input int s);
        if (s == 0) return "R2";
        if (s == 1 || s == 2) return "R3";
        if (s == 5) return "R6";
        if (s == 7 || s == 8) return "R9";
        return "R4";
    endfunction

    always @(negedge clk) begin
        bit e_ras, e_cas, e_col;
        if (cmp_on && !finished) begin
            e_ras = (m_st >= 3 && m_st <= 6) || m_st == 8;
            e_cas = (m_st >= 4 && m_st <= 8);
            e_col = (m_st >= 4 && m_st <= 6);
            if (!rst_n) begin
                chk("R1", "reset state", int'(state_o), 0);
                chk("R1", "reset strobes", int'({ras_o, cas_o, col_sel_o, we_o, done_o}), 0);
            end else begin
                chk(st_tag(m_st), "state", int'(state_o), m_st);
                chk("R7", "ras", int'(ras_o), int'(e_ras));
                chk("R7", "cas", int'(cas_o), int'(e_cas));
                chk("R8", "col_sel", int'(col_sel_o), int'(e_col));
                chk("R8", "we", int'(we_o), int'(e_col && m_wr));
                chk((m_st == 8) ? "R9" : "R4", "done", int'(done_o), int'(m_st == 6 || m_st == 8));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // One cycle issued from idle; counts precharge and wait states at the ports.
    task automatic run_one(input bit rf, input bit both, input bit wr, input bit tp2,
                           input bit pw, input int cnt, input bit xw, input int k,
                           input bit chg, input string tg_tp, input string tg_tw);
        int tp = 0, tw = 0, cw = 0, guard = 0, p, exp_tw;
        bit saw_rf = 0;
        @(posedge clk); #1;
        rfsh_req = rf; acc_req = !rf || both; acc_wr = wr;
        cfg_tp2 = tp2; cfg_pw_en = pw; cfg_pw_cnt = cnt[1:0]; cfg_xw_en = xw; wait_n = 1'b1;
        @(posedge clk); #1;
        rfsh_req = 0; acc_req = 0;
        if (chg) begin
            cfg_tp2 = !tp2; cfg_pw_en = !pw; cfg_pw_cnt = ~cnt[1:0]; cfg_xw_en = !xw;
        end
        while (guard < 60) begin
            if (state_o == 4'd1 || state_o == 4'd2) tp++;
            if (state_o == 4'd7) saw_rf = 1;
            if (state_o == 4'd5) tw++;
            if (state_o == 4'd4 || state_o == 4'd5) begin
                wait_n = (cw < k) ? 1'b0 : 1'b1;
                cw++;
            end else if (rf) begin
                wait_n = 1'b0;
            end else begin
                wait_n = 1'b1;
            end
            if (state_o == 4'd6 || state_o == 4'd8) break;
            @(posedge clk); #1;
            guard++;
        end
        wait_n = 1'b1;
        p = pw ? cnt : 0;
        exp_tw = rf ? 0 : (xw ? ((k > p) ? k : p) : p);
        chk(tg_tp, "precharge states", tp, tp2 ? 2 : 1);
        chk(tg_tw, "wait states", tw, exp_tw);
        chk(rf ? "R9" : "R2", "refresh taken", int'(saw_rf), int'(rf));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        cmp_on = 1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        // R3 / R4 basic read and write, both precharge lengths
        run_one(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3", "R4");
        run_one(0, 0, 1, 1, 0, 0, 0, 0, 0, "R3", "R4");
        // R5 programmed waits
        run_one(0, 0, 1, 0, 1, 3, 0, 0, 0, "R3", "R5");
        run_one(0, 0, 0, 1, 1, 1, 0, 0, 0, "R3", "R5");
        run_one(0, 0, 0, 0, 0, 3, 0, 0, 0, "R3", "R5");
        // R6 external wait: fewer, equal, more low samples than programmed
        run_one(0, 0, 0, 0, 1, 2, 1, 1, 0, "R3", "R6");
        run_one(0, 0, 1, 0, 1, 2, 1, 2, 0, "R3", "R6");
        run_one(0, 0, 0, 1, 1, 2, 1, 5, 0, "R3", "R6");
        run_one(0, 0, 0, 0, 0, 0, 1, 4, 0, "R3", "R6");
        run_one(0, 0, 0, 0, 1, 1, 0, 5, 0, "R3", "R6");
        // R9 refresh, both precharge lengths, WAIT held low
        run_one(1, 0, 0, 0, 1, 3, 1, 4, 0, "R9", "R9");
        run_one(1, 0, 0, 1, 1, 3, 1, 4, 0, "R9", "R9");
        // R2 simultaneous requests: refresh wins
        run_one(1, 1, 1, 0, 0, 0, 0, 0, 0, "R2", "R9");
        // R10 configuration changed right after acceptance
        run_one(0, 0, 1, 0, 1, 1, 0, 0, 1, "R10", "R10");
        run_one(0, 0, 0, 1, 1, 2, 1, 3, 1, "R10", "R10");
        // random back-to-back traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            acc_req  = ($urandom % 3) != 0;
            rfsh_req = ($urandom % 7) == 0;
            acc_wr   = $urandom % 2;
            cfg_tp2  = $urandom % 2;
            cfg_pw_en = $urandom % 2;
            cfg_pw_cnt = 2'($urandom % 4);
            cfg_xw_en = $urandom % 2;
            wait_n   = ($urandom % 3) != 0;
        end
        @(posedge clk); #1;
        acc_req = 0; rfsh_req = 0; wait_n = 1'b1;
        repeat (20) @(posedge clk);
        // R1 reset in the middle of a cycle
        #1 acc_req = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b0; acc_req = 0;
        repeat (2) @(posedge clk);
        #5;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule